// File: doc/BRIEF.md
# Hysteretic Buck Gate-Drive Sequencer

This block sequences the two gate signals of a time-delayed hysteretic buck regulator that holds an LED string at a constant average current. It receives four digitised inputs (a flag that says the sensed load current is above its threshold, an active-high disable, and two supply comparator flags, one for the upper and one for the lower threshold). From these it produces a high-side and a low-side gate command. It has no clock of its own: every interval is a parameter counted in cycles of the system clock.

The switching frequency is free-running. The high side stays on while the current is below threshold. When the flag trips, the high side turns off after a programmable delay, and the low side turns on after a break-before-make gap. The reverse happens when the flag clears. Around this loop sit four other behaviours. Supply lockout keeps both gates low, with hysteresis between the two supply flags. A bootstrap precharge holds the low side on after the supply comes up. A disable state parks the low side on. A watchdog caps any continuous high-side period and inserts a short low-side refresh pulse so the bootstrap capacitor stays charged.

All cycle counts below are measured from the first rising clock edge at which an input shows its new level; that edge counts as 1. The default intervals assume a 125 MHz clock: an 18-cycle gap, a 22-cycle turn-off latency, a 2500-cycle watchdog and a 125-cycle refresh.

Top module: `hbuck_gate_seq`

## Requirements
- R1: After reset, and for as long as the sequencer is in lockout, both gate outputs are low whatever the feedback and disable inputs do. Lockout lasts at least DEAD_CYC cycles every time it is entered.
- R2: Lockout is left only while the upper-threshold flag is 1 and the lower-threshold flag is 0. Once running, a drop of the upper-threshold flag has no effect. The lower-threshold flag going to 1 drives both gates low SYNC_STAGES+1 cycles later.
- R3: On leaving lockout the low side rises SYNC_STAGES+1 cycles after the upper-threshold flag is first seen, provided the minimum lockout time has passed. It stays high with the high side low for exactly PRECHG_CYC cycles. Both gates are then low for DEAD_CYC cycles, and then the high side turns on if the feedback flag is 0.
- R4: With the high side on, a feedback flag of 1 makes the high side fall TRIP_DLY cycles later. The low side rises exactly DEAD_CYC cycles after that.
- R5: With the low side on, a feedback flag of 0 makes the low side fall RET_DLY cycles later. The high side rises exactly DEAD_CYC cycles after that.
- R6: The two gates are never high in the same cycle. Every rise of either gate follows at least DEAD_CYC consecutive cycles with both gates low.
- R7: The high side is never high for more than WDOG_CYC consecutive cycles. When that limit is reached, both gates are low for DEAD_CYC cycles, then the low side is high for REFRESH_CYC cycles, then both are low for DEAD_CYC cycles, and then the high side returns if the feedback flag is 0.
- R8: A disable of 1 makes the high side fall SYNC_STAGES+1 cycles later. The low side rises DEAD_CYC cycles after that. The low side then stays high and the high side low for as long as disable stays 1, whatever the feedback flag does.
- R9: When disable returns to 0 with the feedback flag at 0, the low side falls RET_DLY+1 cycles later. The high side rises DEAD_CYC cycles after that.
- R10: Feedback changes during a gap interval or a refresh pulse are ignored until that interval ends, so a refresh pulse stays exactly REFRESH_CYC cycles long.
- R11: The watchdog count restarts whenever the high side goes low. The first high-side period after any earlier one may last the full WDOG_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_above_i | input | 1 | 1 when the sensed load current is above its threshold (asynchronous) |
| disable_i | input | 1 | 1 stops regulation and parks the low side on (asynchronous) |
| vdd_up_i | input | 1 | 1 when the supply is above the upper lockout threshold (asynchronous) |
| vdd_down_i | input | 1 | 1 when the supply is below the lower lockout threshold (asynchronous) |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |

## Verification
Any wrong internal state shows at the gate pins within one cycle. A sequencer in the wrong state drives a level that does not belong to the present mode, or changes edge timing by at least one cycle. A shared interval counter loaded with the wrong length stretches or shortens exactly one gap, hold, precharge or refresh run, so the bench measures each of these runs to the exact cycle. A watchdog count that does not restart shows up as a shortened high-side period on the first watchdog expiry after a normal switching cycle. Any overlap, or a shortened gap, is caught in the cycle where a gate rises.

// File: rtl/hbuck_seq_pkg.sv
package hbuck_seq_pkg;

   // Sequencer states; the gate levels follow from the state alone.
   typedef enum logic [3:0] {
      ST_LOCKOUT,
      ST_PRECHARGE,
      ST_HS_ON,
      ST_HS_HOLD,
      ST_GAP_TO_LS,
      ST_LS_ON,
      ST_LS_HOLD,
      ST_GAP_TO_HS,
      ST_WD_GAP,
      ST_REFRESH,
      ST_GAP_TO_OFF,
      ST_PARKED
   } seq_state_t;

   // Input bit positions inside the synchroniser vector.
   localparam int IDX_FB   = 0;
   localparam int IDX_DIS  = 1;
   localparam int IDX_UP   = 2;
   localparam int IDX_DOWN = 3;
   localparam int N_IN     = 4;

   function automatic logic hs_drive(input seq_state_t s);
      return (s == ST_HS_ON) || (s == ST_HS_HOLD);
   endfunction

   function automatic logic ls_drive(input seq_state_t s);
      return (s == ST_PRECHARGE) || (s == ST_LS_ON) || (s == ST_LS_HOLD) ||
             (s == ST_REFRESH)   || (s == ST_PARKED);
   endfunction

endpackage

// File: rtl/hbuck_sync.sv
module hbuck_sync #(
   parameter int            N       = 4,
   parameter int            STAGES  = 2,
   parameter logic [N-1:0]  RST_VAL = '0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  d_i,
   output logic [N-1:0]  q_o
);

   logic [N-1:0] pipe [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/hbuck_interval_timer.sv
module hbuck_interval_timer #(
   parameter int            W       = 8,
   parameter logic [W-1:0]  RST_VAL = '0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [W-1:0]  load_val_i,
   output logic          done_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= RST_VAL;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   // done in the last cycle of an interval of length load_val+1
   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/hbuck_watchdog.sv
module hbuck_watchdog #(
   parameter int LIMIT = 2500
)(
   input  logic clk,
   input  logic rst_n,
   input  logic hs_on_i,
   output logic expired_o
);

   localparam int WD_W = $clog2(LIMIT + 1);

   logic [WD_W-1:0] cnt_q;

   // cnt_q holds the number of high-side cycles already completed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (hs_on_i)  cnt_q <= cnt_q + WD_W'(1);
      else               cnt_q <= '0;
   end

   assign expired_o = hs_on_i && (cnt_q == WD_W'(LIMIT - 1));

endmodule

// File: rtl/hbuck_gate_seq.sv
module hbuck_gate_seq
   import hbuck_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEAD_CYC    = 18,
   parameter int TRIP_DLY    = 22,
   parameter int RET_DLY     = 22,
   parameter int PRECHG_CYC  = 250,
   parameter int WDOG_CYC    = 2500,
   parameter int REFRESH_CYC = 125
)(
   input  logic clk,
   input  logic rst_n,
   input  logic fb_above_i,
   input  logic disable_i,
   input  logic vdd_up_i,
   input  logic vdd_down_i,
   output logic hs_gate_o,
   output logic ls_gate_o
);

   // Latencies are end to end; subtract synchroniser and state-entry cycles.
   localparam int TRIP_WAIT = TRIP_DLY - SYNC_STAGES - 1;
   localparam int RET_WAIT  = RET_DLY  - SYNC_STAGES - 1;
   localparam int MAX_A     = (PRECHG_CYC  > REFRESH_CYC) ? PRECHG_CYC : REFRESH_CYC;
   localparam int MAX_B     = (TRIP_WAIT   > RET_WAIT)    ? TRIP_WAIT  : RET_WAIT;
   localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_LEN   = (MAX_C > DEAD_CYC) ? MAX_C : DEAD_CYC;
   localparam int TMR_W     = $clog2(MAX_LEN + 1);
   localparam logic [N_IN-1:0] SYNC_RST = N_IN'(1) << IDX_DOWN;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DEAD_CYC < 1 || PRECHG_CYC < 1 || REFRESH_CYC < 1) begin : g_bad_len
      $error("gap, precharge and refresh lengths must be at least 1");
   end
   if (TRIP_WAIT < 1 || RET_WAIT < 1) begin : g_bad_dly
      $error("TRIP_DLY and RET_DLY must be at least SYNC_STAGES+2");
   end
   if (WDOG_CYC < 2) begin : g_bad_wd
      $error("WDOG_CYC must be at least 2");
   end

   logic [N_IN-1:0] raw_in, syn_in;
   logic fb_s, dis_s, up_s, down_s;

   assign raw_in[IDX_FB]   = fb_above_i;
   assign raw_in[IDX_DIS]  = disable_i;
   assign raw_in[IDX_UP]   = vdd_up_i;
   assign raw_in[IDX_DOWN] = vdd_down_i;

   hbuck_sync #(
      .N       (N_IN),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   assign fb_s   = syn_in[IDX_FB];
   assign dis_s  = syn_in[IDX_DIS];
   assign up_s   = syn_in[IDX_UP];
   assign down_s = syn_in[IDX_DOWN];

   seq_state_t st_q, st_d;
   logic       tmr_done, tmr_load, wd_exp;
   logic [TMR_W-1:0] tmr_val;

   function automatic logic [TMR_W-1:0] span_of(input seq_state_t s);
      int len;
      case (s)
         ST_PRECHARGE: len = PRECHG_CYC;
         ST_HS_HOLD:   len = TRIP_WAIT;
         ST_LS_HOLD:   len = RET_WAIT;
         ST_REFRESH:   len = REFRESH_CYC;
         default:      len = DEAD_CYC;
      endcase
      return TMR_W'(len - 1);
   endfunction

   assign tmr_load = (st_d != st_q);
   assign tmr_val  = span_of(st_d);

   hbuck_interval_timer #(
      .W       (TMR_W),
      .RST_VAL (TMR_W'(DEAD_CYC - 1))
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .done_o     (tmr_done)
   );

   hbuck_watchdog #(
      .LIMIT (WDOG_CYC)
   ) u_wd (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs_on_i   (hs_drive(st_q)),
      .expired_o (wd_exp)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_LOCKOUT:
            if (tmr_done && up_s && !down_s) st_d = ST_PRECHARGE;
         ST_PRECHARGE:
            if (tmr_done) st_d = dis_s ? ST_PARKED : (fb_s ? ST_LS_ON : ST_GAP_TO_HS);
         ST_HS_ON:
            if (dis_s)       st_d = ST_GAP_TO_OFF;
            else if (wd_exp) st_d = ST_WD_GAP;
            else if (fb_s)   st_d = ST_HS_HOLD;
         ST_HS_HOLD:
            if (dis_s)         st_d = ST_GAP_TO_OFF;
            else if (wd_exp)   st_d = ST_WD_GAP;
            else if (tmr_done) st_d = ST_GAP_TO_LS;
         ST_GAP_TO_LS:
            if (dis_s)         st_d = ST_GAP_TO_OFF;
            else if (tmr_done) st_d = ST_LS_ON;
         ST_LS_ON:
            if (dis_s)       st_d = ST_PARKED;
            else if (!fb_s)  st_d = ST_LS_HOLD;
         ST_LS_HOLD:
            if (dis_s)         st_d = ST_PARKED;
            else if (tmr_done) st_d = ST_GAP_TO_HS;
         ST_GAP_TO_HS:
            if (dis_s)         st_d = ST_GAP_TO_OFF;
            else if (tmr_done) st_d = ST_HS_ON;
         ST_WD_GAP:
            if (dis_s)         st_d = ST_GAP_TO_OFF;
            else if (tmr_done) st_d = ST_REFRESH;
         ST_REFRESH:
            if (dis_s)         st_d = ST_PARKED;
            else if (tmr_done) st_d = fb_s ? ST_LS_ON : ST_GAP_TO_HS;
         ST_GAP_TO_OFF:
            if (tmr_done) st_d = ST_PARKED;
         ST_PARKED:
            if (!dis_s) st_d = ST_LS_ON;
         default:
            st_d = ST_LOCKOUT;
      endcase
      // supply loss overrides every running state
      if (st_q != ST_LOCKOUT && down_s) st_d = ST_LOCKOUT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_LOCKOUT;
      else        st_q <= st_d;
   end

   assign hs_gate_o = hs_drive(st_q);
   assign ls_gate_o = ls_drive(st_q);

endmodule

// File: rtl/hbuck_gate_seq_chk.sv
module hbuck_gate_seq_chk #(
   parameter int SYNC_STAGES = 2,
   parameter int DEAD_CYC    = 18,
   parameter int WDOG_CYC    = 2500
)(
   input logic clk,
   input logic rst_n,
   input logic disable_i,
   input logic vdd_down_i,
   input logic hs_gate_o,
   input logic ls_gate_o
);

   localparam int GAP_W = $clog2(DEAD_CYC + 1);
   localparam int RUN_W = $clog2(WDOG_CYC + 2);
   localparam int LAT_W = $clog2(SYNC_STAGES + 2);
   localparam int LAT   = SYNC_STAGES + 1;

   logic [GAP_W-1:0] gap_q;
   logic [RUN_W-1:0] run_q;
   logic [LAT_W-1:0] down_q, dis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         run_q  <= '0;
         down_q <= '0;
         dis_q  <= '0;
      end else begin
         if (hs_gate_o || ls_gate_o)           gap_q <= '0;
         else if (gap_q != GAP_W'(DEAD_CYC))   gap_q <= gap_q + GAP_W'(1);
         if (!hs_gate_o)                       run_q <= '0;
         else if (run_q != RUN_W'(WDOG_CYC+1)) run_q <= run_q + RUN_W'(1);
         if (!vdd_down_i)                      down_q <= '0;
         else if (down_q != LAT_W'(LAT))       down_q <= down_q + LAT_W'(1);
         if (!disable_i)                       dis_q <= '0;
         else if (dis_q != LAT_W'(LAT))        dis_q <= dis_q + LAT_W'(1);
      end
   end

   p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate_o && ls_gate_o));

   p_ls_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate_o) |-> (gap_q == GAP_W'(DEAD_CYC)));

   p_hs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate_o) |-> (gap_q == GAP_W'(DEAD_CYC)));

   p_hs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hs_gate_o |-> (run_q < RUN_W'(WDOG_CYC)));

   p_lockout_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (down_q == LAT_W'(LAT)) |-> (!hs_gate_o && !ls_gate_o));

   p_disable_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q == LAT_W'(LAT)) |-> !hs_gate_o);

endmodule

bind hbuck_gate_seq hbuck_gate_seq_chk #(
   .SYNC_STAGES (SYNC_STAGES),
   .DEAD_CYC    (DEAD_CYC),
   .WDOG_CYC    (WDOG_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disable_i  (disable_i),
   .vdd_down_i (vdd_down_i),
   .hs_gate_o  (hs_gate_o),
   .ls_gate_o  (ls_gate_o)
);

// File: tb/tb_hbuck_gate_seq.sv
`timescale 1ns/1ps
module tb_hbuck_gate_seq;

   localparam int SYNC = 2;
   localparam int DEAD = 18;
   localparam int TRIP = 22;
   localparam int RET  = 22;
   localparam int PRE  = 250;
   localparam int WDOG = 2500;
   localparam int REF  = 125;
   localparam int LIMIT = 10000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fb = 1'b0, dis = 1'b0, up = 1'b0, down = 1'b1;
   logic hs, ls;

   always #4 clk = ~clk;

   hbuck_gate_seq #(
      .SYNC_STAGES (SYNC), .DEAD_CYC (DEAD), .TRIP_DLY (TRIP), .RET_DLY (RET),
      .PRECHG_CYC (PRE), .WDOG_CYC (WDOG), .REFRESH_CYC (REF)
   ) dut (
      .clk (clk), .rst_n (rst_n), .fb_above_i (fb), .disable_i (dis),
      .vdd_up_i (up), .vdd_down_i (down), .hs_gate_o (hs), .ls_gate_o (ls)
   );

   int n_chk = 0, n_bad = 0;

   // expected values derived from the requirements
   function automatic int exp_input_lat();  return SYNC + 1;   endfunction
   function automatic int exp_release_lat(); return RET + 1;   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit sig(input int which);
      case (which)
         0:       return hs == 1'b1;
         1:       return ls == 1'b1;
         default: return (hs == 1'b0) && (ls == 1'b0);
      endcase
   endfunction

   // number of consecutive negedge samples for which the condition holds
   task automatic run_len(input int which, output int n);
      n = 0;
      while (sig(which) && n < LIMIT) begin
         @(negedge clk);
         n++;
      end
   endtask

   // number of negedges until the condition first holds
   task automatic wait_until(input int which, output int n);
      n = 0;
      while (!sig(which) && n < LIMIT) begin
         @(negedge clk);
         n++;
      end
   endtask

   // port monitor for overlap, gap length and high-side run length
   bit mon_en = 0;
   int ovl = 0, gap_bad = 0, gap = 0, hrun = 0, hmax = 0;
   logic p_hs = 0, p_ls = 0;
   always @(negedge clk) begin
      if (mon_en) begin
         if (hs && ls) ovl++;
         if ((hs && !p_hs) || (ls && !p_ls)) if (gap < DEAD) gap_bad++;
         if (!hs && !ls) gap++; else gap = 0;
         if (hs) begin hrun++; if (hrun > hmax) hmax = hrun; end else hrun = 0;
         p_hs = hs;
         p_ls = ls;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL timeout actual=%0d expected=%0d", 100000, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int n, bad;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_en = 1;
      repeat (10) @(negedge clk);
      chk(!hs && !ls, "R1 reset gates low", {hs, ls}, 0);

      // supply low flag cleared but upper flag not yet seen: still locked out
      down = 1'b0;
      fb = 1'b1; dis = 1'b1;
      bad = 0;
      repeat (50) begin @(negedge clk); if (hs || ls) bad++; end
      chk(bad == 0, "R1 lockout ignores inputs", bad, 0);
      fb = 1'b0; dis = 1'b0;
      repeat (5) @(negedge clk);

      // leave lockout: precharge then gap then high side
      up = 1'b1;
      wait_until(1, n);
      chk(n == exp_input_lat(), "R3 precharge start", n, exp_input_lat());
      run_len(1, n);
      chk(n == PRE, "R3 precharge length", n, PRE);
      run_len(2, n);
      chk(n == DEAD, "R3 gap after precharge", n, DEAD);
      chk(hs && !ls, "R3 high side after precharge", {hs, ls}, 2);

      // upper flag drop while running has no effect
      up = 1'b0;
      repeat (30) @(negedge clk);
      chk(hs && !ls, "R2 upper flag drop ignored", {hs, ls}, 2);

      // trip
      fb = 1'b1;
      wait_until(2, n);
      chk(n == TRIP, "R4 high side off latency", n, TRIP);
      run_len(2, n);
      chk(n == DEAD, "R4 gap before low side", n, DEAD);
      chk(ls && !hs, "R4 low side on", {hs, ls}, 1);

      // return
      repeat (10) @(negedge clk);
      fb = 1'b0;
      wait_until(2, n);
      chk(n == RET, "R5 low side off latency", n, RET);
      run_len(2, n);
      chk(n == DEAD, "R5 gap before high side", n, DEAD);
      chk(hs && !ls, "R5 high side on", {hs, ls}, 2);

      // watchdog: full period after a normal cycle proves restart
      run_len(0, n);
      chk(n == WDOG, "R11 full watchdog period after switching", n, WDOG);
      run_len(2, n);
      chk(n == DEAD, "R7 gap before refresh", n, DEAD);
      run_len(1, n);
      chk(n == REF, "R7 refresh width", n, REF);
      run_len(2, n);
      chk(n == DEAD, "R7 gap after refresh", n, DEAD);
      chk(hs && !ls, "R7 high side resumes", {hs, ls}, 2);

      // second watchdog expiry with feedback pulsing inside the refresh
      run_len(0, n);
      chk(n == WDOG, "R7 second watchdog period", n, WDOG);
      run_len(2, n);
      n = 0;
      while (ls && n < LIMIT) begin
         if (n == 3)  fb = 1'b1;
         if (n == 40) fb = 1'b0;
         @(negedge clk);
         n++;
      end
      chk(n == REF, "R10 refresh width with feedback pulse", n, REF);
      run_len(2, n);
      chk(n == DEAD, "R10 gap after refresh", n, DEAD);
      chk(hs && !ls, "R10 high side after refresh", {hs, ls}, 2);

      // disable
      repeat (5) @(negedge clk);
      dis = 1'b1;
      wait_until(2, n);
      chk(n == exp_input_lat(), "R8 disable latency", n, exp_input_lat());
      run_len(2, n);
      chk(n == DEAD, "R8 gap before park", n, DEAD);
      bad = 0;
      for (int i = 0; i < 100; i++) begin
         if (!(ls && !hs)) bad++;
         if (i % 7 == 0) fb = ~fb;
         if (i == 90) fb = 1'b0;
         @(negedge clk);
      end
      chk(bad == 0, "R8 parked levels hold", bad, 0);

      // release
      dis = 1'b0;
      wait_until(2, n);
      chk(n == exp_release_lat(), "R9 release low side off", n, exp_release_lat());
      run_len(2, n);
      chk(n == DEAD, "R9 gap after release", n, DEAD);
      chk(hs && !ls, "R9 high side after release", {hs, ls}, 2);

      // supply loss
      repeat (5) @(negedge clk);
      down = 1'b1;
      wait_until(2, n);
      chk(n == exp_input_lat(), "R2 lockout entry latency", n, exp_input_lat());
      up = 1'b1;
      bad = 0;
      repeat (50) begin @(negedge clk); if (hs || ls) bad++; end
      chk(bad == 0, "R1 lockout holds with lower flag set", bad, 0);
      down = 1'b0;
      wait_until(1, n);
      chk(n == exp_input_lat(), "R2 lockout exit latency", n, exp_input_lat());
      run_len(1, n);
      chk(n == PRE, "R3 second precharge length", n, PRE);
      up = 1'b0;

      // constrained random switching
      for (int i = 0; i < 6000; i++) begin
         int unsigned r;
         r = $urandom;
         if (r % 29 == 0)  fb  = ~fb;
         if (r % 601 == 0) dis = ~dis;
         @(negedge clk);
      end
      fb = 1'b0; dis = 1'b0;
      repeat (100) @(negedge clk);

      chk(ovl == 0, "R6 gates never overlap", ovl, 0);
      chk(gap_bad == 0, "R6 gap before every rise", gap_bad, 0);
      chk(hmax <= WDOG, "R7 high-side run bound", hmax, WDOG);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule